// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block converts an integer operand into an IEEE 754 half, single or double precision number. A 64-bit instruction word controls the conversion. The word selects the source integer width and the destination float format. It also selects a sub-word lane inside the operand, signed or unsigned extension, an absolute-value step, a negate step and one of four rounding modes. The block has a single register stage. It accepts one conversion per clock and presents the packed result one clock later, together with a flag that marks encodings it cannot execute.

Before conversion, the operand passes through a lane-select and extend step. Next come absolute-value and negate rules. Both rules treat the most negative value of the source width as a fixed point. A shared leading-one normalizer feeds three rounders, one per destination format, and the instruction picks which rounder's output is kept.

Top module: `int2fp_conv`

## Requirements
- R1: While rst_ni is low, valid_o, illegal_o and result_o are all zero.
- R2: valid_o equals valid_i from the previous clock. result_o and illegal_o are loaded only on a clock where valid_i is high and hold their value otherwise.
- R3: Instruction fields are decoded as follows:
  - destination format, bits 9:8: 1 = half, 2 = single, 3 = double;
  - source width, bits 11:10: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits;
  - signed flag, bit 13;
  - rounding mode, bits 40:39;
  - lane selector, bits 42:41;
  - negate, bit 45;
  - condition-code write, bit 47;
  - absolute value, bit 49.
- R4: An 8-bit or 16-bit source is taken from operand bit selector×8 upward within the low 32 bits. A 32-bit source is operand bits 31:0, and a 64-bit source is the whole operand. The value is sign-extended when the signed flag is set and zero-extended otherwise.
- R5: illegal_o is set and result_o is zero when any of these holds: the destination format is 0, the condition-code write bit is set, a 16-bit source has an odd selector, or a 32-bit or 64-bit source has a nonzero selector.
- R6: Absolute value applies only to signed sources. It turns every negative value into its magnitude except the most negative value of the source width, which stays unchanged. It has no effect on unsigned sources.
- R7: Negate flips the result sign when absolute value is set or the source is unsigned. For a signed source without absolute value, negate is skipped when the operand equals the most negative value of its width.
- R8: Inexact results are rounded by mode: 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero.
- R9: A zero operand gives +0.0, or -0.0 when negate takes effect.
- R10: A half precision result whose rounded magnitude exceeds the format gives infinity under mode 0 and under the mode that rounds away from zero for that sign. Under the other modes it gives the largest finite value of that sign.
- R11: The result is packed as follows: a half result in bits 15:0, a single result in bits 31:0, a double result in all 64 bits. Unused upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operand are present |
| insn_i | input | 64 | Conversion instruction word |
| src_i | input | 64 | Integer operand |
| valid_o | output | 1 | Result is present |
| result_o | output | 64 | Packed floating-point result |
| illegal_o | output | 1 | Encoding cannot be executed |

## Verification
The hardest cases to reach from the ports sit where the rounding and sign rules meet. One is a 64-bit magnitude that rounds past the half precision range, where the outcome depends on both the sign and the rounding mode. Another is the most negative value of each source width combined with every setting of absolute value and negate. Directed vectors cover the exact minimum patterns for each width, each lane, and full-scale 64-bit values under all four modes. A long run of random instruction words then mixes in special operands (zero, all ones, width minimums), and each result is compared with a behavioural model in the bench that rounds by comparing the remainder against the halfway point.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;

  localparam int unsigned OPND_W = 64;

  // instruction field positions; fixed by the encoding
  localparam int unsigned DST_LSB  = 8;
  localparam int unsigned SRC_LSB  = 10;
  localparam int unsigned SGN_BIT  = 13;
  localparam int unsigned RND_LSB  = 39;
  localparam int unsigned LANE_LSB = 41;
  localparam int unsigned NEG_BIT  = 45;
  localparam int unsigned CC_BIT   = 47;
  localparam int unsigned ABS_BIT  = 49;

  typedef enum logic [1:0] {
    DST_BAD    = 2'd0,
    DST_HALF   = 2'd1,
    DST_SINGLE = 2'd2,
    DST_DOUBLE = 2'd3
  } dst_fmt_e;

  typedef enum logic [1:0] {
    SRC_B8  = 2'd0,
    SRC_B16 = 2'd1,
    SRC_B32 = 2'd2,
    SRC_B64 = 2'd3
  } src_fmt_e;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_DOWN      = 2'd1,
    RND_UP        = 2'd2,
    RND_ZERO      = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    dst_fmt_e  dst;
    src_fmt_e  src;
    logic      is_signed;
    logic      do_abs;
    logic      do_neg;
    logic [1:0] lane;
    rnd_mode_e rnd;
  } ctrl_t;

  function automatic logic [5:0] lead_one(input logic [OPND_W-1:0] v);
    logic [5:0] p;
    p = '0;
    for (int i = 0; i < int'(OPND_W); i++) begin
      if (v[i]) p = 6'(i);
    end
    return p;
  endfunction

endpackage

// File: rtl/int2fp_decode.sv
module int2fp_decode
  import int2fp_pkg::*;
(
  input  logic [OPND_W-1:0] insn_i,
  output ctrl_t             ctrl_o,
  output logic              illegal_o
);

  logic cc_wr;
  logic unused_insn;

  assign unused_insn = ^{insn_i[7:0], insn_i[12], insn_i[38:14], insn_i[44:43],
                         insn_i[46], insn_i[48], insn_i[63:50]};

  always_comb begin
    ctrl_o.dst       = dst_fmt_e'(insn_i[DST_LSB +: 2]);
    ctrl_o.src       = src_fmt_e'(insn_i[SRC_LSB +: 2]);
    ctrl_o.is_signed = insn_i[SGN_BIT];
    ctrl_o.do_abs    = insn_i[ABS_BIT];
    ctrl_o.do_neg    = insn_i[NEG_BIT];
    ctrl_o.lane      = insn_i[LANE_LSB +: 2];
    ctrl_o.rnd       = rnd_mode_e'(insn_i[RND_LSB +: 2]);
    cc_wr            = insn_i[CC_BIT];
  end

  always_comb begin
    illegal_o = 1'b0;
    if (ctrl_o.dst == DST_BAD) illegal_o = 1'b1;
    if (cc_wr) illegal_o = 1'b1;
    if (ctrl_o.src == SRC_B16 && ctrl_o.lane[0]) illegal_o = 1'b1;
    if ((ctrl_o.src == SRC_B32 || ctrl_o.src == SRC_B64) && ctrl_o.lane != 2'd0)
      illegal_o = 1'b1;
  end

endmodule

// File: rtl/int2fp_lane.sv
module int2fp_lane
  import int2fp_pkg::*;
(
  input  src_fmt_e          src_fmt_i,
  input  logic [1:0]        lane_i,
  input  logic              signed_i,
  input  logic              abs_i,
  input  logic              neg_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic              sign_o,
  output logic [OPND_W-1:0] mag_o
);

  logic [31:0]       shifted;
  logic [OPND_W-1:0] ext;
  logic              msb;
  logic              is_min;
  logic              keep_neg;
  logic              neg_eff;

  assign shifted = opnd_i[31:0] >> {lane_i, 3'b000};

  always_comb begin
    unique case (src_fmt_i)
      SRC_B8: begin
        msb    = signed_i & shifted[7];
        ext    = {{(OPND_W-8){msb}}, shifted[7:0]};
        is_min = signed_i && shifted[7:0] == 8'h80;
      end
      SRC_B16: begin
        msb    = signed_i & shifted[15];
        ext    = {{(OPND_W-16){msb}}, shifted[15:0]};
        is_min = signed_i && shifted[15:0] == 16'h8000;
      end
      SRC_B32: begin
        msb    = signed_i & opnd_i[31];
        ext    = {{(OPND_W-32){msb}}, opnd_i[31:0]};
        is_min = signed_i && opnd_i[31:0] == 32'h8000_0000;
      end
      default: begin
        msb    = signed_i & opnd_i[OPND_W-1];
        ext    = opnd_i;
        is_min = signed_i && opnd_i == {1'b1, {(OPND_W-1){1'b0}}};
      end
    endcase
  end

  // two's complement magnitude; the width minimum maps onto itself
  assign mag_o    = msb ? (~ext + 64'd1) : ext;
  assign keep_neg = msb & ~(abs_i & ~is_min);
  assign neg_eff  = neg_i & (abs_i | ~signed_i | ~is_min);
  assign sign_o   = keep_neg ^ neg_eff;

endmodule

// File: rtl/int2fp_norm.sv
module int2fp_norm
  import int2fp_pkg::*;
(
  input  logic [OPND_W-1:0] mag_i,
  output logic [OPND_W-1:0] norm_o,
  output logic [5:0]        msb_pos_o,
  output logic              zero_o
);

  assign msb_pos_o = lead_one(mag_i);
  assign norm_o    = mag_i << (6'd63 - msb_pos_o);
  assign zero_o    = (mag_i == '0);

endmodule

// File: rtl/int2fp_round.sv
module int2fp_round
  import int2fp_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned MANT_W = 23
) (
  input  logic [OPND_W-1:0]       norm_i,
  input  logic [5:0]              msb_pos_i,
  input  logic                    zero_i,
  input  logic                    sign_i,
  input  rnd_mode_e               rnd_i,
  output logic [EXP_W+MANT_W:0]   bits_o
);

  localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned KW   = MANT_W + 2;

  logic [KW-1:0]     kept;
  logic [KW-1:0]     sum;
  logic              guard;
  logic              sticky;
  logic              inc;
  logic              carry;
  logic              ovf;
  logic              to_inf;
  logic [MANT_W-1:0] frac;
  logic [12:0]       e_unb;
  logic [12:0]       e_bias;

  assign kept   = {1'b0, norm_i[OPND_W-1 -: MANT_W+1]};
  assign guard  = norm_i[OPND_W-2-MANT_W];
  assign sticky = |norm_i[OPND_W-3-MANT_W:0];

  always_comb begin
    unique case (rnd_i)
      RND_NEAR_EVEN: inc = guard & (sticky | kept[0]);
      RND_DOWN:      inc = sign_i & (guard | sticky);
      RND_UP:        inc = ~sign_i & (guard | sticky);
      default:       inc = 1'b0;
    endcase
  end

  assign sum    = kept + KW'(inc);
  assign carry  = sum[KW-1];
  assign frac   = carry ? '0 : sum[MANT_W-1:0];
  assign e_unb  = 13'(msb_pos_i) + 13'(carry);
  assign e_bias = e_unb + 13'(BIAS);
  assign ovf    = e_unb > 13'(BIAS);
  assign to_inf = (rnd_i == RND_NEAR_EVEN) | (rnd_i == RND_UP & ~sign_i) |
                  (rnd_i == RND_DOWN & sign_i);

  always_comb begin
    if (zero_i) begin
      bits_o = {sign_i, {(EXP_W+MANT_W){1'b0}}};
    end else if (ovf && to_inf) begin
      bits_o = {sign_i, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
    end else if (ovf) begin
      bits_o = {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};
    end else begin
      bits_o = {sign_i, e_bias[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv
  import int2fp_pkg::*;
#(
  parameter int unsigned HALF_EXP_W = 5,
  parameter int unsigned HALF_MAN_W = 10,
  parameter int unsigned SGL_EXP_W  = 8,
  parameter int unsigned SGL_MAN_W  = 23,
  parameter int unsigned DBL_EXP_W  = 11,
  parameter int unsigned DBL_MAN_W  = 52
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [63:0] insn_i,
  input  logic [63:0] src_i,
  output logic        valid_o,
  output logic [63:0] result_o,
  output logic        illegal_o
);

  localparam int unsigned N_FMT = 3;

  ctrl_t             ctrl;
  logic              illegal;
  logic              sign;
  logic [OPND_W-1:0] mag;
  logic [OPND_W-1:0] norm;
  logic [5:0]        msb_pos;
  logic              zero;
  logic [OPND_W-1:0] fmt_res [N_FMT];
  logic [OPND_W-1:0] conv;

  logic              valid_q;
  logic              ill_q;
  logic [OPND_W-1:0] res_q;

  int2fp_decode u_decode (
    .insn_i    (insn_i),
    .ctrl_o    (ctrl),
    .illegal_o (illegal)
  );

  int2fp_lane u_lane (
    .src_fmt_i (ctrl.src),
    .lane_i    (ctrl.lane),
    .signed_i  (ctrl.is_signed),
    .abs_i     (ctrl.do_abs),
    .neg_i     (ctrl.do_neg),
    .opnd_i    (src_i),
    .sign_o    (sign),
    .mag_o     (mag)
  );

  int2fp_norm u_norm (
    .mag_i     (mag),
    .norm_o    (norm),
    .msb_pos_o (msb_pos),
    .zero_o    (zero)
  );

  for (genvar g = 0; g < int'(N_FMT); g++) begin : g_fmt
    localparam int unsigned EW = (g == 0) ? HALF_EXP_W : (g == 1) ? SGL_EXP_W : DBL_EXP_W;
    localparam int unsigned MW = (g == 0) ? HALF_MAN_W : (g == 1) ? SGL_MAN_W : DBL_MAN_W;
    logic [EW+MW:0] bits;

    int2fp_round #(
      .EXP_W  (EW),
      .MANT_W (MW)
    ) u_round (
      .norm_i    (norm),
      .msb_pos_i (msb_pos),
      .zero_i    (zero),
      .sign_i    (sign),
      .rnd_i     (ctrl.rnd),
      .bits_o    (bits)
    );

    assign fmt_res[g] = OPND_W'(bits);
  end

  always_comb begin
    unique case (ctrl.dst)
      DST_HALF:   conv = fmt_res[0];
      DST_SINGLE: conv = fmt_res[1];
      DST_DOUBLE: conv = fmt_res[2];
      default:    conv = '0;
    endcase
    if (illegal) conv = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        ill_q <= illegal;
        res_q <= conv;
      end
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = ill_q;
  assign result_o  = res_q;

endmodule

// File: rtl/int2fp_conv_chk.sv
module int2fp_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] insn_i,
  input logic [63:0] src_i,
  input logic        valid_o,
  input logic [63:0] result_o,
  input logic        illegal_o
);

  logic unused_src;
  assign unused_src = ^src_i;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o)));

  // R5
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == 64'd0);

  // R5
  cc_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[47]) |=> illegal_o);

  // R5
  no_fmt_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[9:8] == 2'd0) |=> illegal_o);

  // R11
  half_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[9:8] == 2'd1) |=> result_o[63:16] == 48'd0);

  // R11
  single_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[9:8] == 2'd2) |=> result_o[63:32] == 32'd0);

endmodule

bind int2fp_conv int2fp_conv_chk u_chk (.*);

// File: tb/tb_int2fp_conv.sv
module tb_int2fp_conv;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] insn_i = '0;
  logic [63:0] src_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int          checks = 0;
  int          errors = 0;
  logic        exp_valid = 1'b0;
  logic        exp_ill = 1'b0;
  logic [63:0] exp_res = '0;
  string       exp_tag = "R1";

  always #10 clk = ~clk;

  int2fp_conv dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .insn_i    (insn_i),
    .src_i     (src_i),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [63:0] mk(input int dst, input int sf, input bit sg, input int sel,
                                     input int rm, input bit ng, input bit ab, input bit cc);
    logic [63:0] r;
    r = '0;
    r[9:8]   = 2'(dst);
    r[11:10] = 2'(sf);
    r[13]    = sg;
    r[40:39] = 2'(rm);
    r[42:41] = 2'(sel);
    r[45]    = ng;
    r[47]    = cc;
    r[49]    = ab;
    return r;
  endfunction

  function automatic void ref_conv(input logic [63:0] ins, input logic [63:0] s,
                                   output logic [63:0] res, output logic ill);
    int dfmt, sfmt, sel, rm, w, mb, eb, bias, p, e, sh;
    bit sg, ng, ab, cc, negv, ismin, sign, up;
    longint unsigned raw, minv, mag, q, rem, halfv, frac, bits;
    dfmt = int'(ins[9:8]);  sfmt = int'(ins[11:10]);
    sel  = int'(ins[42:41]); rm  = int'(ins[40:39]);
    sg = ins[13]; ng = ins[45]; ab = ins[49]; cc = ins[47];
    ill = (dfmt == 0) || cc || (sfmt == 1 && (sel % 2) == 1) || (sfmt >= 2 && sel != 0);
    res = '0;
    if (ill) return;
    case (sfmt)
      0: begin w = 8;  raw = (64'(s[31:0]) >> (sel * 8)) & 64'hFF; end
      1: begin w = 16; raw = (64'(s[31:0]) >> (sel * 8)) & 64'hFFFF; end
      2: begin w = 32; raw = 64'(s[31:0]); end
      default: begin w = 64; raw = s; end
    endcase
    minv  = 64'd1 << (w - 1);
    negv  = sg && ((raw & minv) != 0);
    ismin = sg && (raw == minv);
    if (!negv) mag = raw;
    else if (w == 64) mag = ~raw + 64'd1;
    else mag = (64'd1 << w) - raw;
    sign = negv && !(ab && !ismin);
    if (ng && (ab || !sg || !ismin)) sign = !sign;
    case (dfmt)
      1: begin mb = 10; eb = 5; end
      2: begin mb = 23; eb = 8; end
      default: begin mb = 52; eb = 11; end
    endcase
    bias = (1 << (eb - 1)) - 1;
    bits = 0;
    if (mag != 0) begin
      p = 63;
      while (((mag >> p) & 64'd1) == 0) p--;
      e = p;
      if (p <= mb) begin
        q = mag << (mb - p);
      end else begin
        sh    = p - mb;
        q     = mag >> sh;
        rem   = mag - (q << sh);
        halfv = 64'd1 << (sh - 1);
        case (rm)
          0: up = (rem > halfv) || (rem == halfv && (q & 64'd1) == 64'd1);
          1: up = sign && rem != 0;
          2: up = !sign && rem != 0;
          default: up = 1'b0;
        endcase
        if (up) q = q + 64'd1;
        if (q == (64'd1 << (mb + 1))) begin
          q = q >> 1;
          e = e + 1;
        end
      end
      frac = q & ((64'd1 << mb) - 64'd1);
      if (e > bias) begin
        if (rm == 0 || (rm == 2 && !sign) || (rm == 1 && sign))
          bits = 64'((1 << eb) - 1) << mb;
        else
          bits = (64'((1 << eb) - 2) << mb) | ((64'd1 << mb) - 64'd1);
      end else begin
        bits = (64'(e + bias) << mb) | frac;
      end
    end
    if (sign) bits = bits | (64'd1 << (mb + eb));
    res = bits;
  endfunction

  task automatic cmp();
    checks++;
    if (valid_o !== exp_valid) begin
      errors++;
      $display("FAIL %s valid_o actual %0b expected %0b", exp_tag, valid_o, exp_valid);
    end
    checks++;
    if (result_o !== exp_res) begin
      errors++;
      $display("FAIL %s result_o actual %h expected %h", exp_tag, result_o, exp_res);
    end
    checks++;
    if (illegal_o !== exp_ill) begin
      errors++;
      $display("FAIL %s illegal_o actual %0b expected %0b", exp_tag, illegal_o, exp_ill);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] ins, input logic [63:0] s,
                      input string tag);
    @(negedge clk);
    cmp();
    valid_i = v;
    insn_i  = ins;
    src_i   = s;
    exp_valid = v;
    exp_tag   = tag;
    if (v) ref_conv(ins, s, exp_res, exp_ill);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] ins;
    logic [63:0] s;
    repeat (3) @(negedge clk);
    cmp(); // R1 reset state
    rst_ni = 1'b1;
    step(1'b0, '0, '0, "R1");

    // R3 R4: byte lanes, signed and unsigned
    for (int sel = 0; sel < 4; sel++) begin
      step(1'b1, mk(2, 0, 1'b1, sel, 0, 1'b0, 1'b0, 1'b0), 64'hDEAD_0000_807F_F005, "R4");
      step(1'b1, mk(1, 0, 1'b0, sel, 0, 1'b0, 1'b0, 1'b0), 64'hDEAD_0000_807F_F005, "R4");
    end
    step(1'b1, mk(2, 1, 1'b1, 0, 0, 1'b0, 1'b0, 1'b0), 64'h0000_0000_8000_FFFE, "R4");
    step(1'b1, mk(2, 1, 1'b1, 2, 0, 1'b0, 1'b0, 1'b0), 64'h0000_0000_8000_FFFE, "R4");
    step(1'b1, mk(3, 2, 1'b1, 0, 0, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_FFFF_FFFE, "R3");
    step(1'b1, mk(3, 3, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'h1234_5678_9ABC_DEF0, "R3");

    // R5: illegal encodings
    step(1'b1, mk(0, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'd7, "R5");
    step(1'b1, mk(2, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1), 64'd7, "R5");
    step(1'b1, mk(2, 1, 1'b0, 1, 0, 1'b0, 1'b0, 1'b0), 64'd7, "R5");
    step(1'b1, mk(2, 1, 1'b0, 3, 0, 1'b0, 1'b0, 1'b0), 64'd7, "R5");
    step(1'b1, mk(2, 2, 1'b0, 2, 0, 1'b0, 1'b0, 1'b0), 64'd7, "R5");
    step(1'b1, mk(3, 3, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0), 64'd7, "R5");

    // R6: absolute value rules
    step(1'b1, mk(1, 0, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0), 64'h80, "R6");
    step(1'b1, mk(1, 0, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0), 64'h85, "R6");
    step(1'b1, mk(2, 1, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0), 64'h8000, "R6");
    step(1'b1, mk(2, 2, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0), 64'h8000_0000, "R6");
    step(1'b1, mk(3, 3, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0), 64'h8000_0000_0000_0000, "R6");
    step(1'b1, mk(2, 0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0), 64'hFF, "R6");

    // R7: negate rules
    step(1'b1, mk(2, 0, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0), 64'h80, "R7");
    step(1'b1, mk(2, 0, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0), 64'hFB, "R7");
    step(1'b1, mk(2, 0, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0), 64'hFF, "R7");
    step(1'b1, mk(2, 0, 1'b1, 0, 0, 1'b1, 1'b1, 1'b0), 64'h80, "R7");
    step(1'b1, mk(3, 3, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0), 64'h8000_0000_0000_0000, "R7");

    // R8: rounding modes
    for (int rm = 0; rm < 4; rm++) begin
      step(1'b1, mk(2, 2, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'h0100_0001, "R8");
      step(1'b1, mk(2, 2, 1'b1, 0, rm, 1'b0, 1'b0, 1'b0), 64'hFEFF_FFFF, "R8");
      step(1'b1, mk(2, 2, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'h0100_0003, "R8");
      step(1'b1, mk(3, 3, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
      step(1'b1, mk(1, 1, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'h0000_0801, "R8");
    end

    // R9: zero operand
    step(1'b1, mk(1, 0, 1'b1, 0, 0, 1'b0, 1'b0, 1'b0), 64'h0, "R9");
    step(1'b1, mk(1, 0, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0), 64'h0, "R9");
    step(1'b1, mk(3, 3, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0), 64'h0, "R9");

    // R10: half overflow
    for (int rm = 0; rm < 4; rm++) begin
      step(1'b1, mk(1, 3, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, "R10");
      step(1'b1, mk(1, 3, 1'b1, 0, rm, 1'b0, 1'b0, 1'b0), 64'h8000_0000_0000_0000, "R10");
      step(1'b1, mk(1, 1, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'hFFF0, "R10");
      step(1'b1, mk(1, 1, 1'b0, 0, rm, 1'b0, 1'b0, 1'b0), 64'hFFE0, "R10");
    end

    // R11: packing per format
    step(1'b1, mk(1, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_0000_0005, "R11");
    step(1'b1, mk(2, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_0000_0005, "R11");
    step(1'b1, mk(3, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'hFFFF_FFFF_0000_0005, "R11");

    // R2: idle cycles hold the last result
    step(1'b0, mk(1, 0, 1'b1, 0, 0, 1'b1, 1'b0, 1'b0), 64'h33, "R2");
    step(1'b0, mk(0, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1), 64'h44, "R2");
    step(1'b1, mk(2, 2, 1'b0, 3, 0, 1'b0, 1'b0, 1'b0), 64'h1, "R2");
    step(1'b0, mk(2, 2, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0), 64'h9, "R2");

    // R4 R8: random instructions and operands
    for (int n = 0; n < 4000; n++) begin
      ins = {$urandom, $urandom};
      ins[47] = ($urandom % 16) == 0;
      case ($urandom % 6)
        0: s = '0;
        1: s = 64'hFFFF_FFFF_FFFF_FFFF;
        2: s = 64'h8000_0000_0000_0000;
        3: s = 64'(32'h8080_8000);
        default: s = {$urandom, $urandom} >> ($urandom % 64);
      endcase
      step(($urandom % 10) != 0, ins, s, "R4");
    end

    step(1'b0, '0, '0, "R2");
    step(1'b0, '0, '0, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule